// File: doc/BRIEF.md
# Modulo-24 Residue Unit

This block takes a valid-qualified unsigned input word and returns its remainder after division by 24. It uses the factorisation 24 = 8 × 3. The three low input bits are already a remainder modulo 8, so they go straight to the low result bits. Only the field above them passes through a small modulo-3 reduction. That reduction is a tree whose partial residues are never wider than two bits.

The result is registered and comes with its own valid flag. A parameter can add one register between the reduction tree and the output register, for timing. Without that register the latency is one cycle. With it the latency is two cycles. Inputs may arrive on every cycle, and results leave in the order they were accepted.

Top module: `mod24_residue`

## Requirements
- R1: `out_res[2:0]` equals bits 2:0 of the accepted input word, unchanged.
- R2: `out_res[4:3]` equals (input >> 3) mod 3, encoded as the binary value 0, 1 or 2.
- R3: `out_res[4:3]` never takes the value 3, so a valid result never exceeds 23.
- R4: With `PIPE` = 0, a word presented with `in_valid` high at one rising edge appears with `out_valid` high after exactly that edge, which is a latency of one cycle.
- R5: With `PIPE` = 1, the same word appears with `out_valid` high one edge later, which is a latency of two cycles.
- R6: While `rst_n` is low, `out_valid` and `out_res` are both 0.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low, after the same latency. During that cycle `out_res` holds the last result.
- R8: Words presented on consecutive cycles are all accepted, and their results leave in the order the words arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_x` |
| in_x | input | IN_W (12) | Unsigned input word |
| out_valid | output | 1 | Qualifies `out_res` |
| out_res | output | 5 | Residue of the input modulo 24 |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One copy has `PIPE` = 0 and the other has `PIPE` = 1. Running both exercises the one-cycle and the two-cycle latency paths against a single scoreboard rule. Both copies use the default 12-bit width. That keeps every one of the 4096 input words within reach of an exhaustive back-to-back sweep, which covers all digit patterns the tree can fold. Gapped traffic then shows the hold behaviour between results.

// File: rtl/mod24_residue.sv
module mod24_residue #(
  parameter int IN_W = 12,
  parameter bit PIPE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_x,
  output logic            out_valid,
  output logic [4:0]      out_res
);
  localparam int UW = IN_W - 3;
  localparam int ND = (UW + 1) / 2;
  localparam int PW = 2 * ND;

  function automatic logic [1:0] fold3(input logic [1:0] d);
    return (d == 2'd3) ? 2'd0 : d;
  endfunction

  function automatic logic [1:0] add3(input logic [1:0] a, input logic [1:0] b);
    case ({a, b})
      4'b00_00, 4'b01_10, 4'b10_01: add3 = 2'd0;
      4'b00_01, 4'b01_00, 4'b10_10: add3 = 2'd1;
      default:                      add3 = 2'd2;
    endcase
  endfunction

  logic [PW-1:0] upper;
  logic [1:0]    node [1:2*ND-1];

  assign upper = PW'(in_x[IN_W-1:3]);

  for (genvar k = 0; k < ND; k++) begin : g_leaf
    assign node[ND+k] = fold3(upper[2*k +: 2]);
  end

  for (genvar i = 1; i < ND; i++) begin : g_tree
    assign node[i] = add3(node[2*i], node[2*i+1]);
  end

  logic       st_v;
  logic [4:0] st_res;

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v   <= 1'b0;
        st_res <= '0;
      end else begin
        st_v <= in_valid;
        if (in_valid) st_res <= {node[1], in_x[2:0]};
      end
    end
  end else begin : g_comb
    assign st_v   = in_valid;
    assign st_res = {node[1], in_x[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= st_v;
      if (st_v) out_res <= st_res;
    end
  end
endmodule

module mod24_residue_chk #(
  parameter int IN_W = 12,
  parameter bit PIPE = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IN_W-1:0] in_x,
  input logic            out_valid,
  input logic [4:0]      out_res
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_res[4:3] != 2'd3);

  if (PIPE) begin : g_two
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);
    assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 (out_res[2:0] == $past(in_x[2:0], 2)));
    assert_upper_mod3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 (out_res[4:3] == 2'(($past(in_x, 2) >> 3) % 3)));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 (!out_valid && $stable(out_res)));
  end else begin : g_one
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_res[2:0] == $past(in_x[2:0])));
    assert_upper_mod3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_res[4:3] == 2'(($past(in_x) >> 3) % 3)));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_res)));
  end
endmodule

bind mod24_residue mod24_residue_chk #(.IN_W(IN_W), .PIPE(PIPE)) u_chk (.*);

// File: tb/mod24_residue_tb.sv
module mod24_residue_tb;
  localparam int IN_W = 12;

  typedef struct packed {
    logic [4:0]  res;
    logic [31:0] cyc;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [IN_W-1:0] in_x = '0;
  logic            ov0, ov1;
  logic [4:0]      or0, or1;

  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  item_t q0[$];
  item_t q1[$];
  logic [4:0] last0 = '0;
  logic [4:0] last1 = '0;
  bit    mon_on = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mod24_residue #(.IN_W(IN_W), .PIPE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(ov0), .out_res(or0));

  mod24_residue #(.IN_W(IN_W), .PIPE(1'b1)) u_dut_p (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(ov1), .out_res(or1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input bit v, input logic [IN_W-1:0] x);
    @(negedge clk);
    in_valid = v;
    in_x     = x;
    if (v) begin
      q0.push_back('{res: 5'(x % 24), cyc: 32'(cyc)});
      q1.push_back('{res: 5'(x % 24), cyc: 32'(cyc)});
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // R4 R5 R7 R8 scoreboard monitors
  always @(negedge clk) begin
    if (mon_on) begin
      bit due0, due1;
      due0 = (q0.size() != 0) && (int'(q0[0].cyc) + 1 == cyc);
      due1 = (q1.size() != 0) && (int'(q1[0].cyc) + 2 == cyc);
      check(ov0 == due0, "R4 out_valid latency PIPE=0", int'(ov0), int'(due0));
      check(ov1 == due1, "R5 out_valid latency PIPE=1", int'(ov1), int'(due1));
      if (due0) begin
        check(or0 == q0[0].res, "R1/R2/R8 residue PIPE=0", int'(or0), int'(q0[0].res));
        check(or0[4:3] != 2'd3, "R3 upper field PIPE=0", int'(or0[4:3]), 2);
        last0 = q0[0].res;
        void'(q0.pop_front());
      end else begin
        check(or0 == last0, "R7 hold PIPE=0", int'(or0), int'(last0));
      end
      if (due1) begin
        check(or1 == q1[0].res, "R1/R2/R8 residue PIPE=1", int'(or1), int'(q1[0].res));
        check(or1[4:3] != 2'd3, "R3 upper field PIPE=1", int'(or1[4:3]), 2);
        last1 = q1[0].res;
        void'(q1.pop_front());
      end else begin
        check(or1 == last1, "R7 hold PIPE=1", int'(or1), int'(last1));
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ov0 == 1'b0 && or0 == 5'd0, "R6 reset state PIPE=0", int'(or0), 0);
    check(ov1 == 1'b0 && or1 == 5'd0, "R6 reset state PIPE=1", int'(or1), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1 R2 R3 R8 exhaustive back-to-back sweep
    for (int x = 0; x < (1 << IN_W); x++) send(1'b1, IN_W'(x));
    // R7 gapped traffic with holds between results
    send(1'b0, '0);
    send(1'b0, '0);
    send(1'b1, 12'd4095);
    send(1'b0, 12'd7);
    send(1'b0, 12'd100);
    send(1'b1, 12'd23);
    send(1'b0, 12'd24);
    send(1'b1, 12'd24);
    send(1'b1, 12'd2047);
    send(1'b0, 12'd0);
    for (int k = 0; k < 64; k++) send(k[0], IN_W'(k * 37 + 5));
    send(1'b0, '0);
    repeat (5) @(negedge clk);
    check(q0.size() == 0, "R8 queue drained PIPE=0", q0.size(), 0);
    check(q1.size() == 0, "R8 queue drained PIPE=1", q1.size(), 0);
    finish_run();
  end
endmodule